// File: doc/BRIEF.md
# Segment Address Translation Unit

This unit turns a logical address into a physical one. A request gives a segment number and an offset. In protected mode the segment number selects one row of a small on-chip table. Each row holds a start address (base) and a length (limit). The unit checks that the segment number lies below a programmable table length and that the offset lies below the row's limit. It then returns base plus offset. If either check fails, it returns a fault.

In legacy mode the table is bypassed entirely. The segment is shifted left by four bits and added to the offset, which gives a 20-bit address with no checks of any kind. A separate origin register holds the in-memory location of the table. Software can write it and the unit shows it on an output, but it takes no part in translation.

Requests use a valid/ready handshake. Ready stays low during reset and high afterwards. Each accepted request produces exactly one result beat on the following clock edge. The table, the length register and the origin register are each written through their own synchronous strobe.

Top module: `seg_xlate_unit`

## Requirements
- R1: While reset is high, `req_ready` is low. After reset, `rsp_valid`, `rsp_fault` and `org_q` are 0, `req_ready` is 1, and the table length is 0, so every protected request faults.
- R2: A protected request (`req_legacy`=0) with segment below the table length and offset below that row's limit yields `rsp_valid`=1 and `rsp_pa` = (base + offset) mod 2^24 on the clock edge after the handshake.
- R3: A protected request whose offset is greater than or equal to the row's limit yields `rsp_fault`=1 and `rsp_valid`=0. A limit of 0 therefore always faults. `rsp_pa` is 0 whenever `rsp_valid` is 0.
- R4: A protected request whose full 16-bit segment number is greater than or equal to the table length faults, even when its low index bits name a programmed row.
- R5: A legacy request (`req_legacy`=1) yields `rsp_valid`=1 and `rsp_pa` = ((segment × 16) + offset) mod 2^20, with bits 23..20 zero. It never faults, whatever the table length or limits are.
- R6: `rsp_valid` and `rsp_fault` are never both 1. A result beat lasts one cycle and appears only on the cycle after an accepted request.
- R7: A length write (`len_we`) of a value above the entry count (8) stores 8, so segment 8 still faults afterwards.
- R8: An origin write (`org_we`) appears on `org_q` one cycle later and has no effect on translation results.
- R9: A request accepted in the same cycle as a table-row write or a length write is translated with the contents held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tw_en | input | 1 | Table row write strobe |
| tw_idx | input | 3 | Row index to write |
| tw_base | input | 24 | Base to store |
| tw_limit | input | 16 | Limit to store |
| len_we | input | 1 | Table length write strobe |
| len_wdata | input | 4 | New table length (saturates at 8) |
| org_we | input | 1 | Origin register write strobe |
| org_wdata | input | 24 | New origin value |
| org_q | output | 24 | Current origin value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit accepts requests |
| req_legacy | input | 1 | 1 = legacy shift-and-add, 0 = protected |
| req_seg | input | 16 | Segment number |
| req_off | input | 16 | Offset |
| rsp_valid | output | 1 | Physical address valid |
| rsp_fault | output | 1 | Segmentation fault |
| rsp_pa | output | 24 | Physical address |

## Verification
The bench targets the boundaries of both checks:
- An offset exactly equal to the limit must fault, and an offset one below it must pass. A design that uses less-or-equal returns an address instead of a fault.
- A segment number whose low three bits name a valid row but whose upper bits do not must fault. A design that compares only the index bits would translate it.
- Legacy requests with a maximum segment and offset must wrap at 20 bits and must not fault when the table length is 0. A design that forgot the mode would fault here or carry into bit 20.

The bench also covers the remaining ordering and side-effect cases:
- A length write of 15 must saturate.
- A write in the same cycle as a request must not leak into that request.
- The origin register must stay out of the datapath.

// File: rtl/sxu_pkg.sv
package sxu_pkg;

  // Translation mode carried by each request
  typedef enum logic {
    XMODE_PROT   = 1'b0,
    XMODE_LEGACY = 1'b1
  } xmode_e;

  // Legacy mode shifts the segment by this many bits
  localparam int LEGACY_SHIFT = 4;

endpackage

// File: rtl/sxu_table.sv
module sxu_table #(
  parameter int ENTRIES = 8,
  parameter int BASE_W  = 24,
  parameter int LIM_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LEN_W  = $clog2(ENTRIES + 1),
  localparam int ROW_W  = BASE_W + LIM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_lim,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              org_we,
  input  logic [BASE_W-1:0] org_in,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_lim,
  output logic [LEN_W-1:0]  len_q,
  output logic [BASE_W-1:0] org_q
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(ENTRIES);

  // Row storage: written on the clock, read combinationally (distributed RAM)
  logic [ROW_W-1:0] rows [ENTRIES];
  logic [ROW_W-1:0] rd_row;

  always_ff @(posedge clk) begin
    if (wr_en) rows[wr_idx] <= {wr_base, wr_lim};
  end

  assign rd_row  = rows[rd_idx];
  assign rd_base = rd_row[ROW_W-1:LIM_W];
  assign rd_lim  = rd_row[LIM_W-1:0];

  // Length register, saturating at the entry count
  logic [LEN_W-1:0] len_sat;
  assign len_sat = (len_in > LEN_MAX) ? LEN_MAX : len_in;

  always_ff @(posedge clk) begin
    if (rst)         len_q <= '0;
    else if (len_we) len_q <= len_sat;
  end

  // Origin register: visible to software, never read by the datapath
  always_ff @(posedge clk) begin
    if (rst)         org_q <= '0;
    else if (org_we) org_q <= org_in;
  end

  // R7
  len_cap_chk: assert property (@(posedge clk) disable iff (rst)
    len_q <= LEN_MAX);

  // R7
  len_load_chk: assert property (@(posedge clk) disable iff (rst)
    len_we |=> (len_q == (($past(len_in) > LEN_MAX) ? LEN_MAX : $past(len_in))));

endmodule

// File: rtl/sxu_calc.sv
module sxu_calc
  import sxu_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 16,
  parameter int LEN_W  = 4,
  localparam int PA_W  = BASE_W,
  localparam int RM_W  = SEG_W + LEGACY_SHIFT,
  localparam int CMP_W = (OFF_W > LIM_W) ? OFF_W : LIM_W
) (
  input  logic              legacy,
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic [BASE_W-1:0] base,
  input  logic [LIM_W-1:0]  lim,
  input  logic [LEN_W-1:0]  len,
  output logic [PA_W-1:0]   pa,
  output logic              fault
);

  xmode_e mode;
  assign mode = xmode_e'(legacy);

  // Protected path: one comparison pair and one addition
  logic            seg_in_table;
  logic            off_in_limit;
  logic [PA_W-1:0] prot_pa;

  assign seg_in_table = seg < SEG_W'(len);
  assign off_in_limit = CMP_W'(off) < CMP_W'(lim);
  assign prot_pa      = PA_W'(base) + PA_W'(off);

  // Legacy path: shift by four and add, wrapping at RM_W bits
  logic [RM_W-1:0] rm_sum;
  assign rm_sum = {seg, {LEGACY_SHIFT{1'b0}}} + RM_W'(off);

  always_comb begin
    if (mode == XMODE_LEGACY) begin
      pa    = PA_W'(rm_sum);
      fault = 1'b0;
    end else begin
      pa    = prot_pa;
      fault = !(seg_in_table && off_in_limit);
    end
  end

endmodule

// File: rtl/sxu_out.sv
module sxu_out #(
  parameter int PA_W = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [PA_W-1:0] pa_next,
  input  logic            fault_next,
  output logic            ready,
  output logic            valid,
  output logic            fault,
  output logic [PA_W-1:0] pa
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      valid <= 1'b0;
      fault <= 1'b0;
      pa    <= '0;
    end else begin
      ready <= 1'b1;
      valid <= fire && !fault_next;
      fault <= fire && fault_next;
      pa    <= (fire && !fault_next) ? pa_next : '0;
    end
  end

  // R6
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(valid && fault));

  // R3
  pa_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (pa == '0));

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
  parameter int ENTRIES = 8,
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int BASE_W  = 24,
  parameter int LIM_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LEN_W  = $clog2(ENTRIES + 1),
  localparam int PA_W   = BASE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tw_en,
  input  logic [IDX_W-1:0]  tw_idx,
  input  logic [BASE_W-1:0] tw_base,
  input  logic [LIM_W-1:0]  tw_limit,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_wdata,
  input  logic              org_we,
  input  logic [BASE_W-1:0] org_wdata,
  output logic [BASE_W-1:0] org_q,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_legacy,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_pa
);

  logic [BASE_W-1:0] row_base;
  logic [LIM_W-1:0]  row_lim;
  logic [LEN_W-1:0]  tbl_len;
  logic [PA_W-1:0]   pa_next;
  logic              fault_next;
  logic              fire;

  assign fire = req_valid && req_ready;

  sxu_table #(
    .ENTRIES (ENTRIES),
    .BASE_W  (BASE_W),
    .LIM_W   (LIM_W)
  ) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tw_en),
    .wr_idx  (tw_idx),
    .wr_base (tw_base),
    .wr_lim  (tw_limit),
    .len_we  (len_we),
    .len_in  (len_wdata),
    .org_we  (org_we),
    .org_in  (org_wdata),
    .rd_idx  (req_seg[IDX_W-1:0]),
    .rd_base (row_base),
    .rd_lim  (row_lim),
    .len_q   (tbl_len),
    .org_q   (org_q)
  );

  sxu_calc #(
    .SEG_W  (SEG_W),
    .OFF_W  (OFF_W),
    .BASE_W (BASE_W),
    .LIM_W  (LIM_W),
    .LEN_W  (LEN_W)
  ) u_calc (
    .legacy (req_legacy),
    .seg    (req_seg),
    .off    (req_off),
    .base   (row_base),
    .lim    (row_lim),
    .len    (tbl_len),
    .pa     (pa_next),
    .fault  (fault_next)
  );

  sxu_out #(
    .PA_W (PA_W)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .pa_next    (pa_next),
    .fault_next (fault_next),
    .ready      (req_ready),
    .valid      (rsp_valid),
    .fault      (rsp_fault),
    .pa         (rsp_pa)
  );

  // R6
  beat_src_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || rsp_fault) |-> $past(req_valid && req_ready));

  // R6
  beat_due_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (rsp_valid || rsp_fault));

  // R5
  legacy_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_legacy) |=> (rsp_valid && (rsp_pa >> 20) == '0));

  // R4
  bound_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_legacy && (req_seg >= SEG_W'(tbl_len))) |=> rsp_fault);

endmodule

// File: tb/seg_xlate_unit_test.sv
`timescale 1ns/1ps
module seg_xlate_unit_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        tw_en;
  logic [2:0]  tw_idx;
  logic [23:0] tw_base;
  logic [15:0] tw_limit;
  logic        len_we;
  logic [3:0]  len_wdata;
  logic        org_we;
  logic [23:0] org_wdata;
  logic [23:0] org_q;
  logic        req_valid;
  logic        req_ready;
  logic        req_legacy;
  logic [15:0] req_seg;
  logic [15:0] req_off;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [23:0] rsp_pa;

  always #2.5 clk = ~clk;

  seg_xlate_unit uut (
    .clk(clk), .rst(rst),
    .tw_en(tw_en), .tw_idx(tw_idx), .tw_base(tw_base), .tw_limit(tw_limit),
    .len_we(len_we), .len_wdata(len_wdata),
    .org_we(org_we), .org_wdata(org_wdata), .org_q(org_q),
    .req_valid(req_valid), .req_ready(req_ready), .req_legacy(req_legacy),
    .req_seg(req_seg), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
  );

  typedef struct {
    bit          fault;
    logic [23:0] pa;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   ended  = 0;
  bit   mon_on = 0;

  // Reference model of the table
  logic [23:0] m_base [8];
  logic [15:0] m_lim  [8];
  int          m_len  = 0;

  function automatic exp_t predict(bit legacy, logic [15:0] seg, logic [15:0] off, string tag);
    exp_t e;
    logic [19:0] lsum;
    logic [23:0] psum;
    e.tag = tag;
    if (legacy) begin
      lsum    = {seg, 4'h0} + {4'h0, off};
      e.fault = 1'b0;
      e.pa    = {4'h0, lsum};
    end else if (int'(seg) >= m_len || off >= m_lim[seg[2:0]]) begin
      e.fault = 1'b1;
      e.pa    = 24'h0;
    end else begin
      psum    = m_base[seg[2:0]] + {8'h0, off};
      e.fault = 1'b0;
      e.pa    = psum;
    end
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clear_strobes();
    tw_en = 0; len_we = 0; org_we = 0; req_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clear_strobes();
    end
  endtask

  task automatic wr_row(int idx, logic [23:0] b, logic [15:0] l);
    @(negedge clk);
    clear_strobes();
    tw_en = 1; tw_idx = 3'(idx); tw_base = b; tw_limit = l;
    m_base[idx] = b; m_lim[idx] = l;
  endtask

  task automatic wr_len(int v);
    @(negedge clk);
    clear_strobes();
    len_we = 1; len_wdata = 4'(v);
    m_len = (v > 8) ? 8 : v;
  endtask

  task automatic send(bit legacy, logic [15:0] seg, logic [15:0] off, string tag);
    @(negedge clk);
    clear_strobes();
    req_valid = 1; req_legacy = legacy; req_seg = seg; req_off = off;
    q.push_back(predict(legacy, seg, off, tag));
  endtask

  // Scoreboard monitor, samples 1 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        if (rsp_valid && rsp_fault)
          check(0, "R6", "valid and fault together", {30'h0, rsp_valid, rsp_fault}, 32'h0);
        if (rsp_valid || rsp_fault) begin
          if (q.size() == 0) begin
            check(0, "R6", "result beat without request", {7'h0, rsp_fault, rsp_pa}, 32'h0);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(rsp_fault == e.fault, e.tag, "fault flag", {31'h0, rsp_fault}, {31'h0, e.fault});
            check(rsp_pa == e.pa, e.tag, "physical address", {8'h0, rsp_pa}, {8'h0, e.pa});
          end
        end else if (q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          check(0, e.tag, "missing result beat", 32'h0, {8'h0, e.pa});
        end
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    rst = 1;
    clear_strobes();
    tw_idx = 0; tw_base = 0; tw_limit = 0; len_wdata = 0; org_wdata = 0;
    req_legacy = 0; req_seg = 0; req_off = 0;
    repeat (4) @(negedge clk);
    check(req_ready == 0, "R1", "ready during reset", {31'h0, req_ready}, 32'h0);
    rst = 0;
    @(posedge clk); #1;
    check(req_ready == 1, "R1", "ready after reset", {31'h0, req_ready}, 32'h1);
    check(rsp_valid == 0 && rsp_fault == 0, "R1", "result flags after reset",
          {30'h0, rsp_valid, rsp_fault}, 32'h0);
    check(org_q == 0, "R1", "origin after reset", {8'h0, org_q}, 32'h0);
    mon_on = 1;

    // R1: length 0 after reset, so a protected request faults
    send(0, 16'd0, 16'd5, "R1");

    // Program the reference table
    wr_row(0, 24'd1400, 16'd1000);
    wr_row(1, 24'd6300, 16'd400);
    wr_row(2, 24'd4300, 16'd400);
    wr_row(3, 24'd3200, 16'd1100);
    wr_row(4, 24'd4700, 16'd1000);
    wr_len(5);

    // R2: in-range translations
    send(0, 16'd0, 16'd999, "R2");
    send(0, 16'd2, 16'd53,  "R2");
    send(0, 16'd3, 16'd852, "R2");
    send(0, 16'd4, 16'd0,   "R2");
    send(0, 16'd1, 16'd399, "R2");

    // R3: offset at or above limit
    send(0, 16'd0, 16'd1000,  "R3");
    send(0, 16'd1, 16'd400,   "R3");
    send(0, 16'd3, 16'hFFFF,  "R3");
    idle(2);

    // R4: segment at or beyond table length
    send(0, 16'd5,   16'd0, "R4");
    send(0, 16'd200, 16'd0, "R4");

    // R5: legacy mode, incl. 20-bit wrap, ignores table state
    send(1, 16'h1234, 16'h0010, "R5");
    send(1, 16'hFFFF, 16'hFFFF, "R5");
    send(1, 16'd9,    16'd0,    "R5");

    // R7: saturating length, plus 24-bit wrap and zero limit
    wr_row(5, 24'd100, 16'd0);
    wr_row(6, 24'd200, 16'd50);
    wr_row(7, 24'hFFFF00, 16'hFFFF);
    wr_len(15);
    send(0, 16'd7, 16'hFFFE, "R2");
    send(0, 16'd8, 16'd0,    "R7");
    send(0, 16'd5, 16'd0,    "R3");
    send(0, 16'd6, 16'd49,   "R7");

    // R9: writes in the same cycle as a request do not leak into it
    @(negedge clk);
    clear_strobes();
    req_valid = 1; req_legacy = 0; req_seg = 16'd2; req_off = 16'd53;
    q.push_back(predict(0, 16'd2, 16'd53, "R9"));
    tw_en = 1; tw_idx = 3'd2; tw_base = 24'h100; tw_limit = 16'd10;
    m_base[2] = 24'h100; m_lim[2] = 16'd10;
    send(0, 16'd2, 16'd53, "R9");
    @(negedge clk);
    clear_strobes();
    req_valid = 1; req_legacy = 0; req_seg = 16'd3; req_off = 16'd852;
    q.push_back(predict(0, 16'd3, 16'd852, "R9"));
    len_we = 1; len_wdata = 4'd1;
    m_len = 1;
    send(0, 16'd3, 16'd852, "R9");
    send(1, 16'd3, 16'd852, "R5");
    idle(1);

    // R8: origin register visible, translation unaffected
    wr_len(8);
    @(negedge clk);
    clear_strobes();
    org_we = 1; org_wdata = 24'hABCDEF;
    @(negedge clk);
    clear_strobes();
    check(org_q == 24'hABCDEF, "R8", "origin readback", {8'h0, org_q}, 32'h00ABCDEF);
    send(0, 16'd0, 16'd1, "R8");
    send(0, 16'd4, 16'd999, "R8");

    idle(4);
    check(q.size() == 0, "R6", "all results delivered", q.size(), 32'h0);
    finish_run();
  end

endmodule